// File: doc/BRIEF.md
# Serial Line Encoder

This block accepts a parallel word through a valid/ready handshake and sends it out on one serial wire, most significant bit first. Three line codes are available: a plain level code, where the wire follows the bit value; a transition code, where a one flips the wire at the start of its bit and a zero leaves it alone; and a return-to-zero code, where a one is a pulse for the first half of the bit and a zero keeps the wire low.

Every bit lasts a fixed, even number of clocks, split into two equal halves by an internal counter. The return-to-zero code uses that split. The code is chosen per word: the select input is captured together with the data. The transition code keeps its wire level from one bit to the next and from one word to the next. Only reset clears it. When the last bit period ends, the block gives a one-cycle completion pulse and becomes ready again in that same cycle, so the next word can follow with a one-cycle gap.

Top module: `serial_line_encoder`

## Requirements
- R1: With format code 2'b00 (level), the wire equals the current bit value for every clock of that bit's period.
- R2: With format code 2'b10 (return-to-zero), a one bit drives the wire high for the first HALF_CLKS clocks of its period and low for the remaining HALF_CLKS clocks.
- R3: With format code 2'b10, a zero bit keeps the wire low for its whole period.
- R4: With format code 2'b01 (transition), the wire inverts in the first clock of each one bit and keeps its level through a zero bit.
- R5: Bits leave in order from bit WORD_W-1 down to bit 0, each lasting 2*HALF_CLKS clocks, with the first period starting in the clock after the word is accepted.
- R6: The transition-code wire level is 0 after reset and is changed only by one bits sent in format 2'b01. Words in other formats and word boundaries leave it unchanged.
- R7: The format is captured when a word is accepted. Changing the select input during a word has no effect on that word.
- R8: When idle, the wire is 0 if the last accepted word used format 2'b00, 2'b10 or 2'b11, and holds the transition-code level if it used 2'b01.
- R9: `done` is high for exactly one clock, the first clock after the last bit period. `busy` falls in that clock, and a word offered in that clock is accepted.
- R10: While `busy` is high, `in_ready` is low and offered words are ignored. Neither the data nor the select input affects the word in progress.
- R11: Format code 2'b11 behaves exactly like level coding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_ready | output | 1 | Block can accept a word (high when not busy) |
| in_data | input | WORD_W | Parallel word to send |
| fmt_sel | input | 2 | Line code: 00 level, 01 transition, 10 return-to-zero, 11 level |
| busy | output | 1 | A word is being sent |
| done | output | 1 | One-cycle pulse after the last bit period |
| line_out | output | 1 | Serial wire |

## Verification
The assertions check these rules on every clock: the one-cycle shape of the completion pulse, its spacing of exactly WORD_W*2*HALF_CLKS busy clocks after acceptance, a low wire when idle for the non-transition codes, a low second half in return-to-zero, a steady transition-code wire except at bit starts, and a captured format that cannot change while busy. Only the bench's sweeps can show that the right bits appear in the right order. The same holds for the transition-code level carried correctly through non-transition words and back-to-back loads, for disturbances during a word having no effect, and for reset clearing the stored wire level.

// File: rtl/sle_pkg.sv
// Shared types for the serial line encoder.
// Assumes: format codes are two bits wide and 2'b11 is an alias of level coding.
package sle_pkg;
    typedef enum logic [1:0] {
        FMT_LEVEL     = 2'b00,
        FMT_MARK      = 2'b01,
        FMT_RZ        = 2'b10,
        FMT_LEVEL_ALT = 2'b11
    } line_fmt_e;
endpackage

// File: rtl/sle_bit_timer.sv
// Bit-period timer: counts clocks inside a bit, flags the second half,
// the last clock of each bit and the last clock of the word.
// Assumes: start is asserted for one cycle while run is low; run stays high
// for exactly the duration of a word.
module sle_bit_timer #(
    parameter int WORD_W    = 8,
    parameter int HALF_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic half_second,
    output logic bit_end,
    output logic word_end
);
    localparam int BIT_CLKS = 2 * HALF_CLKS;
    localparam int CYC_W    = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
    localparam int IDX_W    = (WORD_W > 2) ? $clog2(WORD_W) : 1;

    logic [CYC_W-1:0] cyc_q;
    logic [IDX_W-1:0] idx_q;

    // Position of the current clock inside the bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (start) begin
            cyc_q <= '0;
        end else if (run) begin
            cyc_q <= bit_end ? '0 : cyc_q + 1'b1;
        end
    end

    // Index of the bit being sent, counted from the first one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (start) begin
            idx_q <= '0;
        end else if (bit_end) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Phase and boundary flags derived from the counters.
    always_comb begin
        half_second = (cyc_q >= CYC_W'(HALF_CLKS));
        bit_end     = run && (cyc_q == CYC_W'(BIT_CLKS - 1));
        word_end    = bit_end && (idx_q == IDX_W'(WORD_W - 1));
    end
endmodule

// File: rtl/sle_shifter.sv
// Output shift register: holds the word and presents the bit in flight
// and the one that follows it, shifting toward the top at each bit end.
// Assumes: WORD_W >= 2.
module sle_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              shift,
    output logic              cur_bit,
    output logic              next_bit
);
    logic [WORD_W-1:0] sr_q;

    // Capture a new word or move the next bit into the top position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_data;
        end else if (shift) begin
            sr_q <= {sr_q[WORD_W-2:0], 1'b0};
        end
    end

    // Top bit goes out now; the bit below it is sent next.
    always_comb begin
        cur_bit  = sr_q[WORD_W-1];
        next_bit = sr_q[WORD_W-2];
    end
endmodule

// File: rtl/sle_line_coder.sv
// Line coder: keeps the captured format and the transition-code level and
// turns the bit in flight plus its phase into the wire value.
// Assumes: load happens only while idle; bit_end is qualified by run.
module sle_line_coder
    import sle_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  line_fmt_e load_fmt,
    input  logic      load_first_bit,
    input  logic      run,
    input  logic      bit_end,
    input  logic      word_end,
    input  logic      cur_bit,
    input  logic      next_bit,
    input  logic      half_second,
    output line_fmt_e fmt_q,
    output logic      line_out
);
    logic mark_lvl_q;

    // Format is captured with the word and held until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= FMT_LEVEL;
        end else if (load) begin
            fmt_q <= load_fmt;
        end
    end

    // Transition-code level: flips at the start of every one bit, reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_lvl_q <= 1'b0;
        end else if (load) begin
            if (load_fmt == FMT_MARK) begin
                mark_lvl_q <= mark_lvl_q ^ load_first_bit;
            end
        end else if (bit_end && !word_end && (fmt_q == FMT_MARK)) begin
            mark_lvl_q <= mark_lvl_q ^ next_bit;
        end
    end

    // Wire value from format, bit in flight and half-bit phase.
    always_comb begin
        case (fmt_q)
            FMT_MARK: line_out = mark_lvl_q;
            FMT_RZ:   line_out = run && cur_bit && !half_second;
            default:  line_out = run && cur_bit;
        endcase
    end
endmodule

// File: rtl/serial_line_encoder.sv
// Serial line encoder top: accepts a word on a valid/ready handshake and
// sends it MSB first in the selected line code, then pulses done.
// Assumes: HALF_CLKS >= 1 (bit period is 2*HALF_CLKS clocks), WORD_W >= 2.
module serial_line_encoder
    import sle_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int HALF_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic [1:0]        fmt_sel,
    output logic              busy,
    output logic              done,
    output logic              line_out
);
    logic      accept;
    logic      half_second;
    logic      bit_end;
    logic      word_end;
    logic      cur_bit;
    logic      next_bit;
    line_fmt_e fmt_q;

    // Handshake: a word is taken whenever the block is idle.
    always_comb begin
        in_ready = !busy;
        accept   = in_valid && in_ready;
    end

    // Busy spans the whole word; done marks the clock after it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= word_end;
            if (accept) begin
                busy <= 1'b1;
            end else if (word_end) begin
                busy <= 1'b0;
            end
        end
    end

    sle_bit_timer #(
        .WORD_W    (WORD_W),
        .HALF_CLKS (HALF_CLKS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .run         (busy),
        .half_second (half_second),
        .bit_end     (bit_end),
        .word_end    (word_end)
    );

    sle_shifter #(
        .WORD_W (WORD_W)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (in_data),
        .shift     (bit_end),
        .cur_bit   (cur_bit),
        .next_bit  (next_bit)
    );

    sle_line_coder u_coder (
        .clk            (clk),
        .rst_n          (rst_n),
        .load           (accept),
        .load_fmt       (line_fmt_e'(fmt_sel)),
        .load_first_bit (in_data[WORD_W-1]),
        .run            (busy),
        .bit_end        (bit_end),
        .word_end       (word_end),
        .cur_bit        (cur_bit),
        .next_bit       (next_bit),
        .half_second    (half_second),
        .fmt_q          (fmt_q),
        .line_out       (line_out)
    );
endmodule

// File: rtl/sle_encoder_checker.sv
// Protocol checker for the serial line encoder, bound to the top module.
// Assumes: fmt_q carries the captured two-bit format code.
module sle_encoder_checker #(
    parameter int WORD_W    = 8,
    parameter int HALF_CLKS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       busy,
    input logic       done,
    input logic       line_out,
    input logic [1:0] fmt_q,
    input logic       half_second,
    input logic       bit_end
);
    localparam int TOTAL = WORD_W * 2 * HALF_CLKS;

    logic [31:0] busy_len_q;

    // Number of busy clocks in the current or just-finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len_q <= '0;
        end else if (busy) begin
            busy_len_q <= busy_len_q + 32'd1;
        end else begin
            busy_len_q <= '0;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && busy_len_q == 32'(TOTAL))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fmt_q != 2'b01) |-> !line_out); // R8
    AST_RZ_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fmt_q == 2'b10 && half_second) |-> !line_out); // R2
    AST_MARK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q == 2'b01 && !bit_end && !(in_valid && in_ready)) |=> $stable(line_out)); // R4
    AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fmt_q)); // R7
endmodule

bind serial_line_encoder sle_encoder_checker #(
    .WORD_W    (WORD_W),
    .HALF_CLKS (HALF_CLKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .busy        (busy),
    .done        (done),
    .line_out    (line_out),
    .fmt_q       (fmt_q),
    .half_second (half_second),
    .bit_end     (bit_end)
);

// File: tb/serial_line_encoder_bench.sv
`timescale 1ns/1ps
module serial_line_encoder_bench;
    localparam int W     = 4;
    localparam int HC    = 2;
    localparam int BC    = 2 * HC;
    localparam int TOTAL = W * BC;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [W-1:0] in_data;
    logic [1:0]   fmt_sel;
    logic         busy;
    logic         done;
    logic         line_out;

    int   tests = 0;
    int   fails = 0;
    int   cycles = 0;
    logic bm_mark;

    always #2.5 clk = ~clk;

    serial_line_encoder #(.WORD_W(W), .HALF_CLKS(HC)) u_serial_line_encoder (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .in_data (in_data), .fmt_sel (fmt_sel), .busy (busy), .done (done),
        .line_out (line_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Sends one word starting at a negedge; returns at the done-cycle negedge.
    task automatic send_word(logic [W-1:0] d, logic [1:0] f);
        bit    stream_ok = 1'b1;
        bit    hold_ok   = 1'b1;
        string bad_req   = "R1";
        int    bad_n     = -1;
        int    act_v     = 0;
        int    exp_v     = 0;
        in_valid = 1'b1;
        in_data  = d;
        fmt_sel  = f;
        for (int n = 0; n < TOTAL; n++) begin
            int    k;
            int    p;
            logic  b;
            logic  e;
            string tag;
            @(negedge clk);
            if (n == 0) begin
                in_data = ~d;          // R10: must be ignored while busy
                fmt_sel = f + 2'd1;    // R7: must not affect this word
            end
            if (n == TOTAL - 1) in_valid = 1'b0;
            k = n / BC;
            p = n % BC;
            b = d[W-1-k];              // R5: MSB first
            if (f == 2'b01 && p == 0 && b) bm_mark = ~bm_mark;
            case (f)
                2'b01:   begin e = bm_mark;           tag = "R4+R6"; end
                2'b10:   begin e = b && (p < HC);     tag = b ? "R2" : "R3"; end
                2'b11:   begin e = b;                 tag = "R11"; end
                default: begin e = b;                 tag = "R1"; end
            endcase
            if (line_out !== e && stream_ok) begin
                stream_ok = 1'b0;
                bad_req   = {tag, "+R5+R7"};
                bad_n     = n;
                act_v     = int'(line_out);
                exp_v     = int'(e);
            end
            if (busy !== 1'b1 || done !== 1'b0 || in_ready !== 1'b0) hold_ok = 1'b0;
        end
        check(stream_ok, bad_req,
              $sformatf("wire word %h fmt %0d at clock %0d", d, f, bad_n), act_v, exp_v);
        check(hold_ok, "R10", $sformatf("busy high, ready low through word %h", d),
              int'(hold_ok), 1);
        @(negedge clk);
        check(done === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R9",
              $sformatf("done/busy/ready after word %h", d),
              int'({done, busy, in_ready}), 3'b101);
        check(line_out === ((f == 2'b01) ? bm_mark : 1'b0), "R8",
              $sformatf("idle wire after fmt %0d", f),
              int'(line_out), int'((f == 2'b01) ? bm_mark : 1'b0));
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        fmt_sel  = 2'b00;
        bm_mark  = 1'b0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && line_out === 1'b0 && in_ready === 1'b1,
              "R8", "reset state busy/done/wire/ready",
              int'({busy, done, line_out, in_ready}), 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);

        // Full sweep: every word in every format, back to back (R9 reload on done).
        for (int d = 0; d < (1 << W); d++) begin
            for (int f = 0; f < 4; f++) begin
                send_word(W'(d), 2'(f));
            end
        end

        // Idle hold in transition code (R8).
        if (bm_mark == 1'b0) send_word(4'b1000, 2'b01);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(line_out === bm_mark && busy === 1'b0, "R8", "idle wire held in transition code",
              int'(line_out), int'(bm_mark));

        // Reset clears the stored transition level (R6).
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(line_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R6",
              "wire low during reset", int'(line_out), 0);
        rst_n   = 1'b1;
        bm_mark = 1'b0;
        @(negedge clk);
        send_word(4'b0000, 2'b01);
        send_word(4'b1010, 2'b01);
        send_word(4'b0110, 2'b10);
        send_word(4'b0001, 2'b01);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule